// File: doc/BRIEF.md
# Two-Level Block Lock Controller

This block holds the write-protection state of a sectored nonvolatile array. The array is made of `NUM_BLOCKS` erase blocks of 64 KB each. The block keeps one protect bit per erase block and one master protect bit. Each requested alteration is judged against that state and is either accepted or rejected. The possible alterations are program, block erase, protect one block, set the master bit, and unprotect all blocks.

The protection has two levels. The per-block bits gate data operations (program and erase). The master bit gates every change to the protect bits themselves. A hardware override input lifts the master gate for protecting one block and for unprotecting all blocks.

Several other conditions also refuse a request:
- A low programming-voltage flag refuses every alteration.
- A block index beyond the configured count is refused and never executed.
- While deep power-down is held, no request is seen at all.

A refused request leaves a sticky cause flag behind. The protect bits model nonvolatile cells, so reset does not touch them. Reset clears only the flags and the result pulses.

Top module: `blklock_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, the outputs `err_lock`, `err_vpp`, `err_range`, `op_accept` and `op_reject` are all 0, and reset leaves `lock_bits` and `master_lock` unchanged. From power-up, all protect bits and the master bit are 0.
- R2: A program (code 1) or erase (code 2) is accepted when all of the following hold: the block index `addr[ADDR_W-1:16]` is below `NUM_BLOCKS`, that block's protect bit is 0, and `vpp_ok` is 1. Acceptance is a one-cycle `op_accept` pulse in the cycle after the request.
- R3: A program or erase aimed at a block whose protect bit is 1 is rejected. Rejection gives a one-cycle `op_reject` pulse in the next cycle and sets `err_lock`.
- R4: With `vpp_ok` low, every alteration (codes 1 to 5) is rejected, `err_vpp` is set, and `lock_bits` stay unchanged.
- R5: Program, erase and protect-one-block (code 3) with a block index of `NUM_BLOCKS` or above are rejected, set `err_range`, and change no state.
- R6: An accepted protect-one-block sets exactly the indexed bit of `lock_bits`. An accepted unprotect-all (code 5) clears every bit.
- R7: While `master_lock` is 1, the following hold:
  - Protect-one-block and unprotect-all are rejected with `err_lock` unless `unlock_ovr` is 1.
  - Set-master (code 4) is always rejected with `err_lock`.
  - Once set, `master_lock` never returns to 0.
- R8: While `master_lock` is 0, protect-one-block, unprotect-all and set-master are accepted whatever the value of `unlock_ovr`.
- R9: While `pd_n` is low, a request produces no `op_accept` pulse and no `op_reject` pulse, sets no flag, and changes no protect bit.
- R10: The error flags stay set until a cycle with `clr_status` high, which clears all three flags for the next cycle. Causes from separate rejections accumulate in the flags.
- R11: A rejected request sets exactly one cause flag. The causes are checked in this order: low voltage first, then index range, then lock.
- R12: Codes 0, 6 and 7 have no effect: no pulse, no flag, no change to the protect bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (flags and pulses only) |
| pd_n | input | 1 | Low holds deep power-down; requests are ignored |
| op_valid | input | 1 | A request is present this cycle |
| op_code | input | 3 | 1 program, 2 erase, 3 protect block, 4 set master, 5 unprotect all |
| addr | input | ADDR_W | Target address; the upper IDX_W bits select the block |
| vpp_ok | input | 1 | Programming voltage valid |
| unlock_ovr | input | 1 | Hardware override of the master gate |
| clr_status | input | 1 | Clears the sticky error flags |
| op_accept | output | 1 | Pulse: previous request executed |
| op_reject | output | 1 | Pulse: previous request refused |
| err_lock | output | 1 | Sticky: refused by a protect bit |
| err_vpp | output | 1 | Sticky: refused for low programming voltage |
| err_range | output | 1 | Sticky: refused for a block index out of range |
| master_lock | output | 1 | Master protect bit |
| lock_bits | output | NUM_BLOCKS | Per-block protect bits |

## Verification
Several properties are checked on every cycle:
- At most one cause is reported per request, and an allowed request has no cause.
- `master_lock` never falls.
- An unprotect-all empties `lock_bits`.
- A rejection pulse always comes with a flag.
- A set flag does not drop without a clear or a reset.
- Power-down and low voltage never give an acceptance.

Only the bench's scenarios can show the following:
- The priority order between causes.
- The effect of the override before and after the master bit is set.
- Flags accumulating over several rejections.
- Protect bits surviving reset.
- Ignored op codes and power-down requests leaving the state alone.

// File: rtl/blklock_pkg.sv
// Package: shared operation codes for the block lock controller.
// Assumes a 3-bit request code; codes 6 and 7 are unused and mean "no operation".
package blklock_pkg;
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROGRAM    = 3'd1,
        OP_ERASE      = 3'd2,
        OP_SET_BLK    = 3'd3,
        OP_SET_MASTER = 3'd4,
        OP_CLR_BLKS   = 3'd5
    } blk_op_e;
endpackage

// File: rtl/blklock_judge.sv
// Module: blklock_judge
// Purely combinational permission check for one request.
// Causes are checked in a fixed priority: low voltage, then index range, then lock.
// Assumes IDX_W >= $clog2(NUM_BLOCKS). Protect bits are indexed only when the index is in range.
module blklock_judge
    import blklock_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 5
) (
    input  blk_op_e               op_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic                  vpp_ok_i,
    input  logic                  ovr_i,
    input  logic [NUM_BLOCKS-1:0] lock_i,
    input  logic                  master_i,
    output logic                  allow_o,
    output logic                  viol_vpp_o,
    output logic                  viol_range_o,
    output logic                  viol_lock_o
);
    localparam int SEL_W = $clog2(NUM_BLOCKS);
    localparam logic [IDX_W:0] BLK_LIMIT = (IDX_W+1)'(NUM_BLOCKS);

    logic is_alter, is_data, is_cfg_blk, uses_idx, in_range, blk_locked, locked_out;

    // Classify the request and look up the target block's protect bit.
    always_comb begin
        is_data    = (op_i == OP_PROGRAM) || (op_i == OP_ERASE);
        is_cfg_blk = (op_i == OP_SET_BLK) || (op_i == OP_CLR_BLKS);
        is_alter   = is_data || is_cfg_blk || (op_i == OP_SET_MASTER);
        uses_idx   = is_data || (op_i == OP_SET_BLK);
        in_range   = {1'b0, idx_i} < BLK_LIMIT;
        blk_locked = in_range ? lock_i[idx_i[SEL_W-1:0]] : 1'b0;
        locked_out = (is_data && blk_locked)
                   || (is_cfg_blk && master_i && !ovr_i)
                   || ((op_i == OP_SET_MASTER) && master_i);
    end

    // Apply the cause priority and derive the final verdict.
    always_comb begin
        viol_vpp_o   = is_alter && !vpp_ok_i;
        viol_range_o = is_alter && vpp_ok_i && uses_idx && !in_range;
        viol_lock_o  = is_alter && vpp_ok_i && !(uses_idx && !in_range) && locked_out;
        allow_o      = is_alter && !viol_vpp_o && !viol_range_o && !viol_lock_o;
    end

    // Cause reporting must stay exclusive.
    always_comb begin
        assert_one_cause_R11: assert ($onehot0({viol_vpp_o, viol_range_o, viol_lock_o}));
        assert_allow_clean_R11: assert (!(allow_o && (viol_vpp_o || viol_range_o || viol_lock_o)));
    end
endmodule

// File: rtl/blklock_store.sv
// Module: blklock_store
// Protect bit storage: one bit per erase block plus a master bit.
// The bits model nonvolatile cells. They power up at 0 and are never touched by reset.
// The master bit can only be set. Callers raise at most one enable per cycle.
module blklock_store #(
    parameter int NUM_BLOCKS = 8,
    parameter int SEL_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_blk_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic                  set_master_i,
    input  logic                  clr_all_i,
    output logic [NUM_BLOCKS-1:0] lock_o,
    output logic                  master_o
);
    logic master_q = 1'b0;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic bit_q = 1'b0;
        // Update one block's protect bit on unprotect-all or a matching protect request.
        always_ff @(posedge clk) begin
            if (clr_all_i) begin
                bit_q <= 1'b0;
            end else if (set_blk_i && (sel_i == SEL_W'(b))) begin
                bit_q <= 1'b1;
            end
        end
        assign lock_o[b] = bit_q;
    end

    // The master bit is set once and then held.
    always_ff @(posedge clk) begin
        if (set_master_i) begin
            master_q <= 1'b1;
        end
    end
    assign master_o = master_q;

    assert_master_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_o) |-> master_o);
    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (lock_o == '0));
    assert_set_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_blk_i && !clr_all_i) |=> lock_o[sel_i]);
endmodule

// File: rtl/blklock_errflags.sv
// Module: blklock_errflags
// Sticky cause flags for refused requests. They are cleared by reset or by a
// clear request, and a new cause arriving in the same cycle as a clear still lands.
module blklock_errflags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic set_lock_i,
    input  logic set_vpp_i,
    input  logic set_range_i,
    output logic err_lock_o,
    output logic err_vpp_o,
    output logic err_range_o
);
    logic [2:0] flg_q;

    // Accumulate causes, dropping earlier ones on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= (clr_i ? 3'b000 : flg_q) | {set_lock_i, set_vpp_i, set_range_i};
        end
    end

    assign {err_lock_o, err_vpp_o, err_range_o} = flg_q;

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_i) && ($past(flg_q) != 3'b000)) |-> ((flg_q & $past(flg_q)) == $past(flg_q)));
endmodule

// File: rtl/blklock_ctrl.sv
// Module: blklock_ctrl (top)
// Two-level write-protection controller for a sectored nonvolatile array.
// Judges each request, updates the protect bits when a configuration request succeeds,
// pulses accept or reject one cycle later, and records the cause of each refusal.
// Assumes NUM_BLOCKS is 8, 16 or 32 and that the block index sits above a 64 KB offset.
module blklock_ctrl
    import blklock_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 5,
    parameter int OFFS_W     = 16,
    localparam int ADDR_W    = IDX_W + OFFS_W,
    localparam int SEL_W     = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_n,
    input  logic                  op_valid,
    input  logic [2:0]            op_code,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  vpp_ok,
    input  logic                  unlock_ovr,
    input  logic                  clr_status,
    output logic                  op_accept,
    output logic                  op_reject,
    output logic                  err_lock,
    output logic                  err_vpp,
    output logic                  err_range,
    output logic                  master_lock,
    output logic [NUM_BLOCKS-1:0] lock_bits
);
    if (!(NUM_BLOCKS == 8 || NUM_BLOCKS == 16 || NUM_BLOCKS == 32)) begin : g_bad_count
        $error("NUM_BLOCKS must be 8, 16 or 32");
    end

    blk_op_e          op;
    logic [IDX_W-1:0] idx;
    logic             go, allow, v_vpp, v_range, v_lock;
    logic             acc_q, rej_q;
    logic             unused_offset;

    assign op            = blk_op_e'(op_code);
    assign idx           = addr[ADDR_W-1:OFFS_W];
    assign go            = op_valid && pd_n;
    assign unused_offset = ^addr[OFFS_W-1:0];

    blklock_judge #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) i_judge (
        .op_i        (op),
        .idx_i       (idx),
        .vpp_ok_i    (vpp_ok),
        .ovr_i       (unlock_ovr),
        .lock_i      (lock_bits),
        .master_i    (master_lock),
        .allow_o     (allow),
        .viol_vpp_o  (v_vpp),
        .viol_range_o(v_range),
        .viol_lock_o (v_lock)
    );

    blklock_store #(.NUM_BLOCKS(NUM_BLOCKS), .SEL_W(SEL_W)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_blk_i   (go && allow && (op == OP_SET_BLK)),
        .sel_i       (idx[SEL_W-1:0]),
        .set_master_i(go && allow && (op == OP_SET_MASTER)),
        .clr_all_i   (go && allow && (op == OP_CLR_BLKS)),
        .lock_o      (lock_bits),
        .master_o    (master_lock)
    );

    blklock_errflags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_status),
        .set_lock_i (go && v_lock),
        .set_vpp_i  (go && v_vpp),
        .set_range_i(go && v_range),
        .err_lock_o (err_lock),
        .err_vpp_o  (err_vpp),
        .err_range_o(err_range)
    );

    // Register the verdict into one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            acc_q <= go && allow;
            rej_q <= go && (v_vpp || v_range || v_lock);
        end
    end
    assign op_accept = acc_q;
    assign op_reject = rej_q;

    assert_pd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (!op_accept && !op_reject));
    assert_vpp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !vpp_ok && (op_code != 3'd0) && (op_code < 3'd6)) |=> !op_accept);
    assert_reject_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_reject |-> (err_lock || err_vpp || err_range));
    assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_accept && op_reject));
endmodule

// File: tb/test_blklock_ctrl.sv
module test_blklock_ctrl;
    localparam int NB = 8;
    localparam int IW = 5;
    localparam int OW = 16;
    localparam int NV = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, pd_n = 1'b1, op_valid = 1'b0;
    logic [2:0]    op_code = 3'd0;
    logic [IW+OW-1:0] addr = '0;
    logic          vpp_ok = 1'b1, unlock_ovr = 1'b0, clr_status = 1'b0;
    logic          op_accept, op_reject, err_lock, err_vpp, err_range, master_lock;
    logic [NB-1:0] lock_bits;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    blklock_ctrl #(.NUM_BLOCKS(NB), .IDX_W(IW), .OFFS_W(OW)) i_blklock_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .op_valid(op_valid), .op_code(op_code),
        .addr(addr), .vpp_ok(vpp_ok), .unlock_ovr(unlock_ovr), .clr_status(clr_status),
        .op_accept(op_accept), .op_reject(op_reject), .err_lock(err_lock), .err_vpp(err_vpp),
        .err_range(err_range), .master_lock(master_lock), .lock_bits(lock_bits)
    );

    // Vector fields: op[23:21] idx[20:16] vpp[15] ovr[14] pd_n[13] acc[12] rej[11]
    // flags{lock,vpp,range}[10:8] lock_bits after[7:0]
    localparam logic [23:0] VEC [NV] = '{
        {3'd1, 5'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h00},
        {3'd2, 5'd7,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h00},
        {3'd3, 5'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h04},
        {3'd1, 5'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 8'h04},
        {3'd2, 5'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 8'h04},
        {3'd3, 5'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 8'h04},
        {3'd1, 5'd9,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001, 8'h04},
        {3'd1, 5'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 8'h04},
        {3'd3, 5'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h04},
        {3'd3, 5'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h04},
        {3'd6, 5'd7,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 8'h04},
        {3'd3, 5'd7,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h84},
        {3'd5, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 8'h84},
        {3'd5, 5'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h00},
        {3'd3, 5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h02},
        {3'd0, 5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 8'h02},
        {3'd4, 5'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h02},
        {3'd3, 5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 8'h02},
        {3'd5, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 8'h02},
        {3'd4, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b100, 8'h02},
        {3'd3, 5'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 8'h0A},
        {3'd1, 5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 8'h0A},
        {3'd5, 5'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 8'h00},
        {3'd1, 5'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 8'h00},
        {3'd3, 5'd31, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b001, 8'h00}
    };
    localparam string TAG [NV] = '{
        "R2", "R2", "R6", "R3", "R3", "R4", "R5", "R11", "R8", "R9", "R12", "R6", "R4",
        "R8", "R6", "R12", "R8", "R7", "R7", "R7", "R7", "R3", "R7", "R2", "R5"
    };

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Present one request for a cycle; on return the result pulse is visible.
    task automatic do_op(input logic [2:0] op, input logic [4:0] idx, input logic vpp,
                         input logic ovr, input logic pd);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; addr = {idx, 16'h1234};
        vpp_ok = vpp; unlock_ovr = ovr; pd_n = pd;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0; vpp_ok = 1'b1; unlock_ovr = 1'b0; pd_n = 1'b1;
    endtask

    task automatic clear_flags();
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after power-up and reset
        check("R1", "flags", {29'd0, err_lock, err_vpp, err_range}, 32'd0);
        check("R1", "pulses", {30'd0, op_accept, op_reject}, 32'd0);
        check("R1", "lock_bits", 32'(lock_bits), 32'd0);
        check("R1", "master", 32'(master_lock), 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][23:21], VEC[i][20:16], VEC[i][15], VEC[i][14], VEC[i][13]);
            check(TAG[i], $sformatf("vec%0d accept", i), 32'(op_accept), 32'(VEC[i][12]));
            check(TAG[i], $sformatf("vec%0d reject", i), 32'(op_reject), 32'(VEC[i][11]));
            check(TAG[i], $sformatf("vec%0d flags", i), {29'd0, err_lock, err_vpp, err_range}, 32'(VEC[i][10:8]));
            check(TAG[i], $sformatf("vec%0d lock_bits", i), 32'(lock_bits), 32'(VEC[i][7:0]));
            clear_flags();
        end
        check("R7", "master after table", 32'(master_lock), 32'd1);

        // R10: causes accumulate, persist while idle, and drop on clear
        do_op(3'd1, 5'd20, 1'b1, 1'b0, 1'b1);
        check("R10", "first cause", {29'd0, err_lock, err_vpp, err_range}, 32'b001);
        do_op(3'd1, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R10", "accumulated", {29'd0, err_lock, err_vpp, err_range}, 32'b011);
        repeat (3) @(negedge clk);
        check("R10", "held idle", {29'd0, err_lock, err_vpp, err_range}, 32'b011);
        clear_flags();
        check("R10", "cleared", {29'd0, err_lock, err_vpp, err_range}, 32'b000);

        // R1: reset clears flags but keeps protect bits and master
        do_op(3'd3, 5'd4, 1'b1, 1'b1, 1'b1);
        check("R7", "override protect", 32'(lock_bits), 32'h10);
        do_op(3'd2, 5'd0, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "flags after reset", {29'd0, err_lock, err_vpp, err_range}, 32'd0);
        check("R1", "pulses after reset", {30'd0, op_accept, op_reject}, 32'd0);
        check("R1", "lock kept", 32'(lock_bits), 32'h10);
        check("R1", "master kept", 32'(master_lock), 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule